// File: doc/BRIEF.md
# Binary Neural Classifier Pipeline

This block scores a 16x16 image of single-bit pixels against ten class weight vectors of single bits and reports the class with the highest score. A class score is the number of pixel positions where image and weight agree, i.e. the popcount of their bitwise XNOR. Every score therefore lies between 0 and 256.

The datapath is output stationary. One class is accumulated completely, one 16-bit row per cycle, before the next class begins. Five pipeline stages are used:

- an address stage that steps a class counter and a row counter;
- a read stage that registers the returned rows with their tags;
- an execute stage that does the XNOR, popcount and accumulation;
- a compare stage that keeps the running maximum and its index;
- a finish stage that holds the answer until all ten classes are done.

A single start pulse launches a run. The block then drives read requests to an external image and weight store with a one-cycle read latency. When the run completes it raises a done flag and presents the winning digit as a 4-bit binary number.

Top module: `bnn_classifier`

## Requirements
- R1: While reset is asserted, and after it until the first start, `done_o` is 0, `class_o` is 0 and `rd_en_o` is 0.
- R2: After the clock edge that samples `start_i` high, `rd_en_o` is high for exactly 160 consecutive cycles. The address goes class-major: `rd_cls_o` runs 0 to 9, and within each class `rd_row_o` runs 0 to 15. Then `rd_en_o` goes low and stays low.
- R3: The score of class c is the sum over rows r of the number of ones in XNOR(image row r, weight row r of class c). It ranges from 0 to 256 without wrapping, and 256 is reachable.
- R4: When done, `class_o` is the index (0 to 9, plain binary) of the largest score.
- R5: `done_o` rises on the 163rd rising edge after the edge that samples `start_i`, counting that edge as edge 0.
- R6: Once high, `done_o` and `class_o` hold their values until the next start.
- R7: The edge that samples `start_i` clears `done_o` and `class_o` to 0. This also holds during a run: the run in flight is abandoned, no partial result from it appears, and reading restarts at class 0 row 0.
- R8: On equal top scores the lowest class index is reported.
- R9: `class_o` reads 0 whenever `done_o` is low.
- R10: Read data is taken one cycle after the request: the rows on `img_row_i` and `wgt_row_i` in the cycle after a request are the ones used for that request's class and row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a classification |
| rd_en_o | output | 1 | Read request to the image and weight store |
| rd_cls_o | output | 4 | Class part of the weight address |
| rd_row_o | output | 4 | Row address (image and weight) |
| img_row_i | input | 16 | Image row returned one cycle after the request |
| wgt_row_i | input | 16 | Weight row returned one cycle after the request |
| done_o | output | 1 | Result valid; held until the next start |
| class_o | output | 4 | Winning class index in binary |

## Verification
The hardest case to reach from the ports is a restart while reads are still in flight. At that moment the read, execute and compare registers each hold a row or a finished score from the abandoned run. To reach it, the bench fires a second start about sixty cycles into a run, after rewriting the store so that a different class wins. The result must reflect only the new contents. Ties are reached by giving two classes weights identical to the image, and the 256 ceiling by making every class match exactly.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
    localparam int unsigned BNN_PIX_W   = 16;
    localparam int unsigned BNN_ROWS    = 16;
    localparam int unsigned BNN_CLASSES = 10;
endpackage

// File: rtl/bnn_popcnt.sv
module bnn_popcnt #(
    parameter int unsigned W     = 16,
    parameter int unsigned OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [OUT_W-1:0] cnt_o
);
    logic [OUT_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
            acc = acc + OUT_W'(vec_i[i]);
        end
    end

    assign cnt_o = acc;
endmodule

// File: rtl/bnn_idx_gen.sv
module bnn_idx_gen #(
    parameter int unsigned CLASSES = 10,
    parameter int unsigned ROWS    = 16,
    localparam int unsigned CLS_W  = $clog2(CLASSES),
    localparam int unsigned ROW_AW = $clog2(ROWS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              rd_en_o,
    output logic [CLS_W-1:0]  cls_o,
    output logic [ROW_AW-1:0] row_o
);
    localparam logic [CLS_W-1:0]  LAST_CLS = CLS_W'(CLASSES - 1);
    localparam logic [ROW_AW-1:0] LAST_ROW = ROW_AW'(ROWS - 1);

    typedef struct packed {
        logic              run;
        logic [CLS_W-1:0]  cls;
        logic [ROW_AW-1:0] row;
    } idx_t;

    idx_t idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (start_i) begin
            idx_d.run = 1'b1;
            idx_d.cls = '0;
            idx_d.row = '0;
        end else if (idx_q.run) begin
            if (idx_q.row == LAST_ROW) begin
                idx_d.row = '0;
                if (idx_q.cls == LAST_CLS) begin
                    idx_d.run = 1'b0;
                    idx_d.cls = '0;
                end else begin
                    idx_d.cls = idx_q.cls + 1'b1;
                end
            end else begin
                idx_d.row = idx_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) idx_q <= '0;
        else         idx_q <= idx_d;
    end

    assign rd_en_o = idx_q.run;
    assign cls_o   = idx_q.cls;
    assign row_o   = idx_q.row;
endmodule

// File: rtl/bnn_mac.sv
module bnn_mac #(
    parameter int unsigned PIX_W   = 16,
    parameter int unsigned ROWS    = 16,
    parameter int unsigned CLASSES = 10,
    localparam int unsigned CLS_W   = $clog2(CLASSES),
    localparam int unsigned ROW_AW  = $clog2(ROWS),
    localparam int unsigned POP_W   = $clog2(PIX_W + 1),
    localparam int unsigned SCORE_W = $clog2(PIX_W * ROWS + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               flush_i,
    input  logic               rd_en_i,
    input  logic [CLS_W-1:0]   cls_i,
    input  logic [ROW_AW-1:0]  row_i,
    input  logic [PIX_W-1:0]   img_i,
    input  logic [PIX_W-1:0]   wgt_i,
    output logic               sc_vld_o,
    output logic [CLS_W-1:0]   sc_cls_o,
    output logic [SCORE_W-1:0] sc_o
);
    localparam logic [ROW_AW-1:0] LAST_ROW = ROW_AW'(ROWS - 1);

    typedef struct packed {
        // read stage: tags of the request whose data is arriving
        logic               rr_vld;
        logic [CLS_W-1:0]   rr_cls;
        logic [ROW_AW-1:0]  rr_row;
        // execute stage operands
        logic               ex_vld;
        logic [CLS_W-1:0]   ex_cls;
        logic [ROW_AW-1:0]  ex_row;
        logic [PIX_W-1:0]   ex_img;
        logic [PIX_W-1:0]   ex_wgt;
        // class accumulator and finished score
        logic [SCORE_W-1:0] acc;
        logic               sc_vld;
        logic [CLS_W-1:0]   sc_cls;
        logic [SCORE_W-1:0] score;
    } mac_t;

    mac_t mac_d, mac_q;

    logic [PIX_W-1:0]   agree;
    logic [POP_W-1:0]   pop;
    logic [SCORE_W-1:0] sum;

    assign agree = ~(mac_q.ex_img ^ mac_q.ex_wgt);

    bnn_popcnt #(.W(PIX_W), .OUT_W(POP_W)) u_pop (
        .vec_i (agree),
        .cnt_o (pop)
    );

    // the first row of a class restarts the sum (output stationary)
    assign sum = ((mac_q.ex_row == '0) ? '0 : mac_q.acc) + SCORE_W'(pop);

    always_comb begin
        mac_d        = mac_q;
        mac_d.rr_vld = rd_en_i;
        mac_d.rr_cls = cls_i;
        mac_d.rr_row = row_i;

        mac_d.ex_vld = mac_q.rr_vld;
        if (mac_q.rr_vld) begin
            mac_d.ex_cls = mac_q.rr_cls;
            mac_d.ex_row = mac_q.rr_row;
            mac_d.ex_img = img_i;
            mac_d.ex_wgt = wgt_i;
        end

        mac_d.sc_vld = 1'b0;
        if (mac_q.ex_vld) begin
            mac_d.acc = sum;
            if (mac_q.ex_row == LAST_ROW) begin
                mac_d.sc_vld = 1'b1;
                mac_d.sc_cls = mac_q.ex_cls;
                mac_d.score  = sum;
            end
        end

        if (flush_i) begin
            mac_d.rr_vld = 1'b0;
            mac_d.ex_vld = 1'b0;
            mac_d.sc_vld = 1'b0;
            mac_d.acc    = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mac_q <= '0;
        else         mac_q <= mac_d;
    end

    assign sc_vld_o = mac_q.sc_vld;
    assign sc_cls_o = mac_q.sc_cls;
    assign sc_o     = mac_q.score;
endmodule

// File: rtl/bnn_argmax.sv
module bnn_argmax #(
    parameter int unsigned CLASSES = 10,
    parameter int unsigned SCORE_W = 9,
    localparam int unsigned CLS_W  = $clog2(CLASSES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               sc_vld_i,
    input  logic [CLS_W-1:0]   sc_cls_i,
    input  logic [SCORE_W-1:0] sc_i,
    output logic               done_o,
    output logic [CLS_W-1:0]   class_o
);
    localparam logic [CLS_W-1:0] LAST_CLS = CLS_W'(CLASSES - 1);

    typedef struct packed {
        logic [SCORE_W-1:0] best;
        logic [CLS_W-1:0]   best_cls;
        logic               done;
        logic [CLS_W-1:0]   res;
    } amax_t;

    amax_t am_d, am_q;
    logic  beats;

    // strictly greater only: an equal later class never displaces an earlier one
    assign beats = sc_i > am_q.best;

    always_comb begin
        am_d = am_q;
        if (clear_i) begin
            am_d = '0;
        end else if (sc_vld_i) begin
            if (beats) begin
                am_d.best     = sc_i;
                am_d.best_cls = sc_cls_i;
            end
            if (sc_cls_i == LAST_CLS) begin
                am_d.done = 1'b1;
                am_d.res  = beats ? sc_cls_i : am_q.best_cls;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) am_q <= '0;
        else         am_q <= am_d;
    end

    assign done_o  = am_q.done;
    assign class_o = am_q.res;
endmodule

// File: rtl/bnn_classifier.sv
module bnn_classifier #(
    parameter int unsigned PIX_W   = bnn_pkg::BNN_PIX_W,
    parameter int unsigned ROWS    = bnn_pkg::BNN_ROWS,
    parameter int unsigned CLASSES = bnn_pkg::BNN_CLASSES,
    localparam int unsigned CLS_W   = $clog2(CLASSES),
    localparam int unsigned ROW_AW  = $clog2(ROWS),
    localparam int unsigned SCORE_W = $clog2(PIX_W * ROWS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              rd_en_o,
    output logic [CLS_W-1:0]  rd_cls_o,
    output logic [ROW_AW-1:0] rd_row_o,
    input  logic [PIX_W-1:0]  img_row_i,
    input  logic [PIX_W-1:0]  wgt_row_i,
    output logic              done_o,
    output logic [CLS_W-1:0]  class_o
);
    logic               sc_vld;
    logic [CLS_W-1:0]   sc_cls;
    logic [SCORE_W-1:0] sc;

    bnn_idx_gen #(.CLASSES(CLASSES), .ROWS(ROWS)) u_idx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .rd_en_o (rd_en_o),
        .cls_o   (rd_cls_o),
        .row_o   (rd_row_o)
    );

    bnn_mac #(.PIX_W(PIX_W), .ROWS(ROWS), .CLASSES(CLASSES)) u_mac (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flush_i  (start_i),
        .rd_en_i  (rd_en_o),
        .cls_i    (rd_cls_o),
        .row_i    (rd_row_o),
        .img_i    (img_row_i),
        .wgt_i    (wgt_row_i),
        .sc_vld_o (sc_vld),
        .sc_cls_o (sc_cls),
        .sc_o     (sc)
    );

    bnn_argmax #(.CLASSES(CLASSES), .SCORE_W(SCORE_W)) u_amax (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (start_i),
        .sc_vld_i (sc_vld),
        .sc_cls_i (sc_cls),
        .sc_i     (sc),
        .done_o   (done_o),
        .class_o  (class_o)
    );
endmodule

// File: rtl/bnn_classifier_chk.sv
module bnn_classifier_chk #(
    parameter int unsigned ROWS    = 16,
    parameter int unsigned CLASSES = 10,
    localparam int unsigned CLS_W  = $clog2(CLASSES),
    localparam int unsigned ROW_AW = $clog2(ROWS)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              rd_en_o,
    input logic [CLS_W-1:0]  rd_cls_o,
    input logic [ROW_AW-1:0] rd_row_o,
    input logic              done_o,
    input logic [CLS_W-1:0]  class_o
);
    localparam logic [CLS_W-1:0]  LAST_CLS = CLS_W'(CLASSES - 1);
    localparam logic [ROW_AW-1:0] LAST_ROW = ROW_AW'(ROWS - 1);
    localparam logic [CLS_W-1:0]  N_CLS    = CLS_W'(CLASSES);

    p_start_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (rd_en_o && rd_cls_o == '0 && rd_row_o == '0 && !done_o && class_o == '0));

    p_row_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_o && !start_i && rd_row_o != LAST_ROW) |=>
        (rd_en_o && rd_row_o == $past(rd_row_o) + 1'b1 && rd_cls_o == $past(rd_cls_o)));

    p_class_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_o && !start_i && rd_row_o == LAST_ROW && rd_cls_o != LAST_CLS) |=>
        (rd_en_o && rd_row_o == '0 && rd_cls_o == $past(rd_cls_o) + 1'b1));

    p_last_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_o && !start_i && rd_row_o == LAST_ROW && rd_cls_o == LAST_CLS) |=> !rd_en_o);

    p_no_read_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !rd_en_o);

    p_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && $stable(class_o)));

    p_class_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (class_o < N_CLS));

    p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> (class_o == '0));
endmodule

bind bnn_classifier bnn_classifier_chk #(.ROWS(ROWS), .CLASSES(CLASSES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .rd_en_o  (rd_en_o),
    .rd_cls_o (rd_cls_o),
    .rd_row_o (rd_row_o),
    .done_o   (done_o),
    .class_o  (class_o)
);

// File: tb/bnn_classifier_tb.sv
module bnn_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [3:0]  rd_cls;
    logic [3:0]  rd_row;
    logic [15:0] img_row = '0;
    logic [15:0] wgt_row = '0;
    logic        done;
    logic [3:0]  cls_out;

    int tests = 0;
    int fails = 0;

    logic [15:0] img_mem [16];
    logic [15:0] wgt_mem [160];

    always #2 clk = ~clk;   // 250 MHz

    bnn_classifier u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .rd_en_o   (rd_en),
        .rd_cls_o  (rd_cls),
        .rd_row_o  (rd_row),
        .img_row_i (img_row),
        .wgt_row_i (wgt_row),
        .done_o    (done),
        .class_o   (cls_out)
    );

    // store with one-cycle read latency (R10)
    always @(posedge clk) begin
        if (rd_en) begin
            img_row <= img_mem[rd_row];
            if (int'(rd_cls) < 10) wgt_row <= wgt_mem[int'(rd_cls) * 16 + int'(rd_row)];
        end
    end

    // ---------------- reference model ----------------
    bit active = 1'b0;
    int k = 0;
    int exp_res = 0;

    function automatic int ref_argmax();
        int best = -1;
        int win = 0;
        for (int c = 0; c < 10; c++) begin
            int s = 0;
            for (int r = 0; r < 16; r++) s += $countones(~(img_mem[r] ^ wgt_mem[c*16 + r]));
            if (s > best) begin best = s; win = c; end  // R8: first maximum wins
        end
        return win;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            active = 1'b0;
            k = 0;
        end else if (start) begin
            active = 1'b1;
            k = 0;
            exp_res = ref_argmax();
        end else if (active && k < 100000) begin
            k = k + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit exp_rd;
        bit exp_done;
        int exp_cls;
        exp_rd   = active && k < 160;
        exp_done = active && k >= 163;
        exp_cls  = exp_done ? exp_res : 0;
        if (!rst_n) begin
            chk(rd_en == 1'b0 && done == 1'b0 && cls_out == 4'd0, "R1", "reset outputs",
                int'({rd_en, done, cls_out}), 0);
        end else begin
            chk(rd_en == exp_rd, "R2", "rd_en", int'(rd_en), int'(exp_rd));
            if (exp_rd) begin
                chk(int'(rd_cls) == k / 16, "R2", "rd_cls", int'(rd_cls), k / 16);
                chk(int'(rd_row) == k % 16, "R2", "rd_row", int'(rd_row), k % 16);
            end
            chk(done == exp_done, "R5", "done timing", int'(done), int'(exp_done));
            if (exp_done)
                chk(int'(cls_out) == exp_cls, "R4", "winning class (scores per R3, R10)",
                    int'(cls_out), exp_cls);
            else
                chk(cls_out == 4'd0, "R9", "class while not done", int'(cls_out), 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [15:0] rnd16();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed[15:0];
    endfunction

    task automatic fill_image();
        for (int r = 0; r < 16; r++) img_mem[r] = rnd16();
    endtask

    // classes with win_mask bit set copy the image; others differ in at least one bit
    task automatic fill_weights(input logic [9:0] win_mask);
        for (int c = 0; c < 10; c++)
            for (int r = 0; r < 16; r++) begin
                logic [15:0] m;
                m = rnd16();
                if (r == 0) m[0] = 1'b1;
                wgt_mem[c*16 + r] = win_mask[c] ? img_mem[r] : (img_mem[r] ^ m);
            end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic full_run();
        pulse_start();
        repeat (175) @(negedge clk);   // includes done hold window (R6)
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: run did not finish, cycles 150000 expected fewer");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) img_mem[r] = '0;
        for (int i = 0; i < 160; i++) wgt_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);    // R1: idle after reset

        // R3, R8: every class scores 256, class 0 must win
        fill_image();
        fill_weights(10'h3FF);
        full_run();

        // every class scores 0 (weights are the complement): class 0
        for (int i = 0; i < 160; i++) wgt_mem[i] = ~img_mem[i % 16];
        full_run();

        // single winners, including the last class
        fill_image(); fill_weights(10'b0010000000); full_run();   // 7
        fill_image(); fill_weights(10'b1000000000); full_run();   // 9
        fill_image(); fill_weights(10'b0000000010); full_run();   // 1

        // R8: tie between classes 3 and 6
        fill_image(); fill_weights(10'b0001001000); full_run();

        // random contents
        for (int n = 0; n < 4; n++) begin
            fill_image();
            for (int i = 0; i < 160; i++) wgt_mem[i] = rnd16();
            full_run();
        end

        // R7: restart in the middle of a run with new contents
        fill_image(); fill_weights(10'b0000000100);
        pulse_start();
        repeat (60) @(negedge clk);
        fill_image(); fill_weights(10'b0000100000);
        full_run();

        // R7: restart while finish stage registers are busy (near the end)
        fill_image(); fill_weights(10'b0000000001);
        pulse_start();
        repeat (161) @(negedge clk);
        fill_image(); fill_weights(10'b0100000000);
        full_run();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule